// File: doc/BRIEF.md
# Per-Core Low-Power Mode Sequencer

This block is a small hardware state machine that sits beside one processor core and carries out that core's idle sequence. Software first writes a two-bit mode code. When the core later raises its wait-for-interrupt indication, the sequencer captures the mode and runs the matching sequence: plain standby, retention at reduced voltage, local power-down, or full power collapse. It drives the clock-gate, voltage-reduce, power-switch and core-reset controls. It holds the low-power condition until a wake interrupt arrives. It then undoes each step in the reverse order and lets the core run again only after the cluster reports that it is ready.

Every voltage or supply change must settle before the sequence moves on. The settle time comes either from a settle-done handshake input or from a programmable cycle count. A wake interrupt that arrives while power is still being removed is held, so the exit starts as soon as the entry is complete. After any mode deeper than standby, the programmed mode falls back to standby.

Top module: `lpm_seq`

## Requirements
- R1: While reset is asserted, mode_q is 00, busy is 0, seq_state is 0, and clk_gate, vdd_low, pwr_off, core_rst and sys_sleep_ok are all 0.
- R2: A sequence starts on a rising edge of wfi seen in the idle state, and seq_state leaves 0 one clock edge later. If wfi stays high after a sequence ends, no new sequence starts.
- R3: With mode 00 (standby), the sequence goes from state 3 to state 5 to state 0. The clock-gate, voltage, power and reset outputs stay low throughout, and state 5 is held until cluster_ready is 1.
- R4: With mode 01 (retention), the states run 1, 2, 3, 4, 5, 0. clk_gate is high in every busy state, and vdd_low is high only in states 2 and 3.
- R5: With mode 10 (local power-down), the states run 1, 2, 3, 4, 5, 0. clk_gate and core_rst are high in every busy state, pwr_off is high only in states 2 and 3, and core_rst falls only after cluster_ready has been seen.
- R6: Mode 11 (power collapse) follows the R5 sequence, and in addition sys_sleep_ok is high exactly while in state 3.
- R7: When a sequence in mode 01, 10 or 11 returns to idle, mode_q becomes 00. A standby sequence leaves mode_q unchanged.
- R8: In states 2 and 4, with settle_ack_en=1 the sequencer stays until settle_done is 1. With settle_ack_en=0 each of these states lasts settle_cycles+1 clock cycles.
- R9: A wake_irq pulse received during state 1 or 2 is held. State 3 then lasts exactly one cycle before the exit begins.
- R10: A mode_wr is accepted only while busy is 0. Writes made while busy leave mode_q unchanged.
- R11: seq_state encodes 0 idle, 1 enter, 2 power-down settle, 3 wait for interrupt, 4 power-up settle, 5 wait for cluster ready. busy is 1 exactly when seq_state is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 2 | Mode code to write (00 standby, 01 retention, 10 local power-down, 11 power collapse) |
| wfi | input | 1 | Core wait-for-interrupt indication |
| wake_irq | input | 1 | Wake interrupt |
| settle_ack_en | input | 1 | 1: use settle_done handshake, 0: use cycle counter |
| settle_done | input | 1 | Supply/voltage settled indication |
| settle_cycles | input | CNT_W | Settle count used when the handshake is off |
| cluster_ready | input | 1 | Cache hierarchy and system ready for core resume |
| mode_q | output | 2 | Programmed mode |
| clk_gate | output | 1 | Core clock gate enable |
| vdd_low | output | 1 | Lower core voltage to retention level |
| pwr_off | output | 1 | Open core power switch |
| core_rst | output | 1 | Hold core in reset |
| sys_sleep_ok | output | 1 | Deeper system sleep permitted |
| busy | output | 1 | Sequence in progress |
| seq_state | output | 3 | Current sequencer state |

## Verification
Every control output is decoded from the state register, so a result appears one clock edge after the input that causes it: the wfi edge, a settle indication, the held interrupt, or cluster_ready. The bench drives inputs on falling edges and also samples on falling edges, so each sample lands half a period after the edge that made the change. A monitor compares every change of the output vector against the next step that the driver has queued, which checks the order of steps independently of how long each one lasts. Durations such as settle_cycles+1 and the one-cycle wait after a held interrupt are measured by counting the falling edges that fall within a given state.

// File: rtl/lpm_seq.sv
module lpm_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  input  logic             wfi,
  input  logic             wake_irq,
  input  logic             settle_ack_en,
  input  logic             settle_done,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic             cluster_ready,
  output logic [1:0]       mode_q,
  output logic             clk_gate,
  output logic             vdd_low,
  output logic             pwr_off,
  output logic             core_rst,
  output logic             sys_sleep_ok,
  output logic             busy,
  output logic [2:0]       seq_state
);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_ENTER = 3'd1;
  localparam logic [2:0] S_DOWN  = 3'd2;
  localparam logic [2:0] S_WAIT  = 3'd3;
  localparam logic [2:0] S_UP    = 3'd4;
  localparam logic [2:0] S_READY = 3'd5;

  logic [2:0]       st;
  logic [1:0]       m;
  logic             wfi_q, irq_pend;
  logic [CNT_W-1:0] cnt;

  wire start   = wfi & ~wfi_q & (st == S_IDLE);
  wire settled = settle_ack_en ? settle_done : (cnt == '0);
  wire stby    = (m == 2'b00);
  wire in_low  = (st == S_DOWN) || (st == S_WAIT);

  assign busy         = (st != S_IDLE);
  assign seq_state    = st;
  assign clk_gate     = busy && !stby;
  assign vdd_low      = in_low && (m == 2'b01);
  assign pwr_off      = in_low && m[1];
  assign core_rst     = busy && m[1];
  assign sys_sleep_ok = (st == S_WAIT) && (m == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      m        <= 2'b00;
      mode_q   <= 2'b00;
      wfi_q    <= 1'b0;
      irq_pend <= 1'b0;
      cnt      <= '0;
    end else begin
      wfi_q <= wfi;
      if (st == S_IDLE || (st == S_WAIT && irq_pend)) irq_pend <= 1'b0;
      else if (wake_irq)                              irq_pend <= 1'b1;
      if (mode_wr && st == S_IDLE && !start) mode_q <= mode_wdata;
      case (st)
        S_IDLE: if (start) begin
          m  <= mode_q;
          st <= (mode_q == 2'b00) ? S_WAIT : S_ENTER;
        end
        S_ENTER: begin
          cnt <= settle_cycles;
          st  <= S_DOWN;
        end
        S_DOWN:
          if (settled)          st  <= S_WAIT;
          else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
        S_WAIT: if (irq_pend) begin
          cnt <= settle_cycles;
          st  <= stby ? S_READY : S_UP;
        end
        S_UP:
          if (settled)          st  <= S_READY;
          else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
        S_READY: if (cluster_ready) begin
          st <= S_IDLE;
          if (!stby) mode_q <= 2'b00;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != S_READY) |=> (mode_q == $past(mode_q))); // R10
  AST_OFF_NEEDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |-> (core_rst && clk_gate)); // R5
  AST_RELEASE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> $past(cluster_ready)); // R5
  AST_SLEEP_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sys_sleep_ok |-> pwr_off); // R6
  AST_NO_LOW_AND_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(vdd_low && pwr_off)); // R4
  AST_HELD_IRQ_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && irq_pend) |=> (st != S_WAIT)); // R9
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    st <= S_READY); // R11

endmodule

// File: tb/sim_lpm_seq.sv
module sim_lpm_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, mode_wr, wfi, wake_irq, settle_ack_en, settle_done, cluster_ready;
  logic [1:0] mode_wdata, mode_q;
  logic [7:0] settle_cycles;
  logic clk_gate, vdd_low, pwr_off, core_rst, sys_sleep_ok, busy;
  logic [2:0] seq_state;

  lpm_seq #(.CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .wfi(wfi), .wake_irq(wake_irq), .settle_ack_en(settle_ack_en),
    .settle_done(settle_done), .settle_cycles(settle_cycles),
    .cluster_ready(cluster_ready), .mode_q(mode_q), .clk_gate(clk_gate),
    .vdd_low(vdd_low), .pwr_off(pwr_off), .core_rst(core_rst),
    .sys_sleep_ok(sys_sleep_ok), .busy(busy), .seq_state(seq_state)
  );

  int n_chk = 0, n_bad = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [8:0] prev = '0, cur, e;
  string      t;

  function automatic logic [8:0] vec_now();
    return {seq_state, clk_gate, vdd_low, pwr_off, core_rst, sys_sleep_ok, busy};
  endfunction

  function automatic logic [8:0] mk(int s, bit cg, bit vl, bit po, bit cr, bit so);
    return {3'(s), cg, vl, po, cr, so, (s != 0)};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(logic [8:0] v, string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  always @(negedge clk) if (rst_n === 1'b1) begin
    cur = vec_now();
    if (cur !== prev) begin
      if (exp_q.size() == 0) check(0, "R11", "unexpected step", int'(cur), int'(prev));
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cur === e, t, "step", int'(cur), int'(e));
      end
      prev = cur;
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic wait_st(int s);
    while (seq_state != 3'(s)) @(negedge clk);
  endtask
  task automatic write_mode(logic [1:0] v);
    mode_wr = 1'b1; mode_wdata = v; @(negedge clk); mode_wr = 1'b0;
  endtask
  task automatic pulse_settle; settle_done = 1'b1; @(negedge clk); settle_done = 1'b0; endtask
  task automatic pulse_irq;    wake_irq = 1'b1;    @(negedge clk); wake_irq = 1'b0;    endtask
  task automatic release_core(string req);
    wait_st(5);
    tick(3);
    check(seq_state == 3'd5, req, "held until cluster_ready", int'(seq_state), 5);
    cluster_ready = 1'b1; @(negedge clk); cluster_ready = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", int'(seq_state), 0);
    summary();
    $finish;
  end

  initial begin
    int n;
    rst_n = 0; mode_wr = 0; mode_wdata = 0; wfi = 0; wake_irq = 0;
    settle_ack_en = 1; settle_done = 0; settle_cycles = 8'd3; cluster_ready = 0;
    tick(3);
    check(mode_q == 2'b00, "R1", "reset mode_q", int'(mode_q), 0);
    check(vec_now() == 9'd0, "R1", "reset outputs", int'(vec_now()), 0);
    rst_n = 1;
    tick(2);

    // standby: R3
    push(mk(3,0,0,0,0,0), "R3"); push(mk(5,0,0,0,0,0), "R3"); push(mk(0,0,0,0,0,0), "R3");
    wfi = 1; @(negedge clk);
    check(seq_state == 3'd3, "R2", "started one edge after wfi rise", int'(seq_state), 3);
    tick(3);
    check(seq_state == 3'd3, "R3", "waits for interrupt", int'(seq_state), 3);
    pulse_irq();
    release_core("R3");
    tick(4);
    check(busy == 1'b0, "R2", "no retrigger while wfi stays high", int'(busy), 0);
    check(mode_q == 2'b00, "R7", "standby keeps mode", int'(mode_q), 0);
    wfi = 0; tick(2);

    // retention with settle handshake: R4, R8, R10
    write_mode(2'b01);
    check(mode_q == 2'b01, "R10", "write accepted when idle", int'(mode_q), 1);
    push(mk(1,1,0,0,0,0), "R4"); push(mk(2,1,1,0,0,0), "R4"); push(mk(3,1,1,0,0,0), "R4");
    push(mk(4,1,0,0,0,0), "R4"); push(mk(5,1,0,0,0,0), "R4"); push(mk(0,0,0,0,0,0), "R4");
    wfi = 1;
    wait_st(2); tick(4);
    check(seq_state == 3'd2, "R8", "waits for settle_done", int'(seq_state), 2);
    pulse_settle();
    wait_st(3);
    write_mode(2'b10);
    check(mode_q == 2'b01, "R10", "write ignored while busy", int'(mode_q), 1);
    pulse_irq();
    wait_st(4); tick(2);
    check(seq_state == 3'd4, "R8", "power-up waits for settle_done", int'(seq_state), 4);
    pulse_settle();
    release_core("R4");
    wfi = 0; tick(2);
    check(mode_q == 2'b00, "R7", "fallback after retention", int'(mode_q), 0);

    // local power-down with cycle counter: R5, R8
    settle_ack_en = 0;
    write_mode(2'b10);
    push(mk(1,1,0,0,1,0), "R5"); push(mk(2,1,0,1,1,0), "R5"); push(mk(3,1,0,1,1,0), "R5");
    push(mk(4,1,0,0,1,0), "R5"); push(mk(5,1,0,0,1,0), "R5"); push(mk(0,0,0,0,0,0), "R5");
    wfi = 1;
    wait_st(2);
    n = 0; while (seq_state == 3'd2) begin n++; @(negedge clk); end
    check(n == 4, "R8", "down settle cycles", n, 4);
    pulse_irq();
    wait_st(4);
    n = 0; while (seq_state == 3'd4) begin n++; @(negedge clk); end
    check(n == 4, "R8", "up settle cycles", n, 4);
    release_core("R5");
    wfi = 0; tick(2);
    check(mode_q == 2'b00, "R7", "fallback after power-down", int'(mode_q), 0);

    // power collapse with early interrupt: R6, R9
    settle_ack_en = 1;
    write_mode(2'b11);
    push(mk(1,1,0,0,1,0), "R6"); push(mk(2,1,0,1,1,0), "R6"); push(mk(3,1,0,1,1,1), "R6");
    push(mk(4,1,0,0,1,0), "R6"); push(mk(5,1,0,0,1,0), "R6"); push(mk(0,0,0,0,0,0), "R6");
    wfi = 1;
    wait_st(2);
    pulse_irq();
    tick(2);
    check(seq_state == 3'd2, "R9", "entry completes despite irq", int'(seq_state), 2);
    pulse_settle();
    n = 0; while (seq_state == 3'd3) begin n++; @(negedge clk); end
    check(n == 1, "R9", "held irq wait length", n, 1);
    pulse_settle();
    release_core("R6");
    wfi = 0; tick(2);
    check(mode_q == 2'b00, "R7", "fallback after collapse", int'(mode_q), 0);
    check(exp_q.size() == 0, "R11", "all steps observed", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule